// File: doc/BRIEF.md
# Five-Level Leg Redundant Switch-State Selector

This block drives one phase leg of a five-level inverter in which a flying-capacitor stage feeds a floating-capacitor H-bridge from a single DC link. For each carrier period it receives the pole level that the modulator asks for (0 to 4, in quarter steps of the link voltage), the direction of the phase current, and digitized voltages of the two floating capacitors: the large one (nominally half the link) and the small one (nominally a quarter of the link). It returns a four-bit switch code with bit 3 as the top switch and bit 0 as the bottom switch.

Levels 1, 2 and 3 can each be made by more than one switch code, and each code charges, discharges or leaves alone each capacitor. A hysteresis comparator per capacitor keeps a "needs charge" flag. The selector scores every candidate code against the wanted direction for each capacitor, with the small capacitor ruling first. It then registers the winner on a carrier-period strobe so that the gates never chatter within one PWM period. Balancing can be switched off per capacitor, and a level code outside 0..4 produces an all-off code and an error flag.

Top module: `fcap_state_sel`

## Requirements
- R1: After reset `sw` is 4'b0000, `need1`, `need2` and `lvl_err` are 0.
- R2: On every clock edge each need flag is set when its capacitor voltage is strictly below REF minus BAND, is cleared when strictly above REF plus BAND, and otherwise holds; voltages equal to either threshold hold the flag.
- R3: `sw` and `lvl_err` change only on a clock edge where `strobe` is 1; they then take the selection computed from the inputs and need flags present before that edge.
- R4: Level 0 yields 4'b0000 and level 4 yields 4'b1111.
- R5: Level 1 selects among 0001, 0110, 1010 (listed order); level 2 among 1000, 0100; level 3 among 0101, 1001, 1110.
- R6: With current positive (`cur_neg`=0) the effects on (large, small) capacitor are: 0001 (none, discharge), 0110 (discharge, charge), 1010 (charge, charge), 1000 (charge, none), 0100 (discharge, none), 0101 (discharge, discharge), 1001 (charge, discharge), 1110 (none, charge). An enabled capacitor wants charge when its need flag is 1 and discharge when it is 0; a code scores +1 for a capacitor when its effect matches the want, -1 when it opposes it, 0 for no effect.
- R7: With `cur_neg`=1 every charge effect in R6 becomes a discharge and every discharge a charge before scoring.
- R8: A capacitor whose enable (`bal_en1`, `bal_en2`) is 0 scores 0 for every code.
- R9: The chosen code has the highest small-capacitor score; among equals the highest large-capacitor score; remaining ties go to the earliest code in the R5 order.
- R10: Levels 5 to 7 yield 4'b0000 with `lvl_err`=1; the next strobe with a valid level returns `lvl_err` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe | input | 1 | Carrier-period update pulse |
| level | input | 3 | Commanded pole level, 0..4 valid |
| cur_neg | input | 1 | 1 when the phase current is negative |
| vc1 | input | VW | Large capacitor voltage sample |
| vc2 | input | VW | Small capacitor voltage sample |
| bal_en1 | input | 1 | Balancing enable, large capacitor |
| bal_en2 | input | 1 | Balancing enable, small capacitor |
| sw | output | 4 | Switch code, bit 3 top switch to bit 0 bottom |
| need1 | output | 1 | Large capacitor needs charge |
| need2 | output | 1 | Small capacitor needs charge |
| lvl_err | output | 1 | Last strobed level was out of range |

## Verification
The bench builds the block with VW=8, REF1=128, REF2=64 and BAND=4, so both hysteresis thresholds of each capacitor, and the band between them, are reached with small voltage steps and the held state inside the band can be shown. With those values the bench can place each need flag at either state in two cycles, which makes it cheap to sweep every level code 0..7, both current signs, all four need combinations and all four enable combinations against an independently written scoring model. Directed cases then isolate the small-capacitor priority, the listed-order tie break and the strobe gating.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

  localparam int NSLOT = 3;

  typedef logic [3:0] sw_t;

  typedef enum logic [1:0] {
    EF_NONE = 2'd0,
    EF_CHG  = 2'd1,
    EF_DIS  = 2'd2
  } eff_e;

  typedef struct packed {
    logic valid;
    sw_t  code;
    eff_e e1;   // large capacitor, positive current
    eff_e e2;   // small capacitor, positive current
  } cand_t;

  // Candidate table: slot order is the tie-break order.
  function automatic cand_t cand_of(input logic [2:0] lvl, input int slot);
    cand_t c;
    c = '{valid: 1'b0, code: 4'b0000, e1: EF_NONE, e2: EF_NONE};
    case (lvl)
      3'd0: if (slot == 0) c = '{1'b1, 4'b0000, EF_NONE, EF_NONE};
      3'd1: begin
        if (slot == 0) c = '{1'b1, 4'b0001, EF_NONE, EF_DIS};
        if (slot == 1) c = '{1'b1, 4'b0110, EF_DIS,  EF_CHG};
        if (slot == 2) c = '{1'b1, 4'b1010, EF_CHG,  EF_CHG};
      end
      3'd2: begin
        if (slot == 0) c = '{1'b1, 4'b1000, EF_CHG,  EF_NONE};
        if (slot == 1) c = '{1'b1, 4'b0100, EF_DIS,  EF_NONE};
      end
      3'd3: begin
        if (slot == 0) c = '{1'b1, 4'b0101, EF_DIS,  EF_DIS};
        if (slot == 1) c = '{1'b1, 4'b1001, EF_CHG,  EF_DIS};
        if (slot == 2) c = '{1'b1, 4'b1110, EF_NONE, EF_CHG};
      end
      3'd4: if (slot == 0) c = '{1'b1, 4'b1111, EF_NONE, EF_NONE};
      default: c = '{1'b0, 4'b0000, EF_NONE, EF_NONE};
    endcase
    return c;
  endfunction

  // Reverse current swaps the sense of every effect.
  function automatic eff_e flip(input eff_e e, input logic neg);
    if (!neg) return e;
    case (e)
      EF_CHG:  return EF_DIS;
      EF_DIS:  return EF_CHG;
      default: return EF_NONE;
    endcase
  endfunction

  // +1 helps, -1 hurts, 0 neutral or balancing disabled.
  function automatic logic signed [1:0] score_of(input eff_e e, input logic en,
                                                 input logic need);
    if (!en || e == EF_NONE) return 2'sd0;
    if ((e == EF_CHG) == need) return 2'sd1;
    return -2'sd1;
  endfunction

  // Lexicographic key: small capacitor weighs three times the large one.
  function automatic logic signed [3:0] rank_of(input logic signed [1:0] s2,
                                                input logic signed [1:0] s1);
    logic signed [3:0] a, b;
    a = $signed({{2{s2[1]}}, s2});
    b = $signed({{2{s1[1]}}, s1});
    return (a <<< 1) + a + b;
  endfunction

endpackage

// File: rtl/fcap_hyst.sv
module fcap_hyst #(
  parameter int VW   = 10,
  parameter int REF  = 512,
  parameter int BAND = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] v,
  output logic          need
);
  localparam logic [VW:0] LO = (VW+1)'(REF - BAND);
  localparam logic [VW:0] HI = (VW+1)'(REF + BAND);

  logic below, above;
  assign below = {1'b0, v} < LO;
  assign above = {1'b0, v} > HI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     need <= 1'b0;
    else if (below) need <= 1'b1;
    else if (above) need <= 1'b0;
  end
endmodule

// File: rtl/fcap_pick.sv
module fcap_pick
  import fcap_pkg::*;
(
  input  logic [2:0] level,
  input  logic       cur_neg,
  input  logic [1:0] need,
  input  logic [1:0] en,
  output sw_t        code,
  output logic       lvl_bad,
  output logic [1:0] slot
);
  logic signed [3:0] rank [NSLOT];
  logic [NSLOT-1:0]  ok;
  sw_t               codes [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    cand_t c;
    eff_e  f1, f2;
    always_comb begin
      c  = cand_of(level, k);
      f1 = flip(c.e1, cur_neg);
      f2 = flip(c.e2, cur_neg);
    end
    assign ok[k]    = c.valid;
    assign codes[k] = c.code;
    assign rank[k]  = rank_of(score_of(f2, en[1], need[1]),
                              score_of(f1, en[0], need[0]));
  end

  assign lvl_bad = level > 3'd4;

  always_comb begin
    logic signed [3:0] best;
    slot = 2'd0;
    best = rank[0];
    for (int k = 1; k < NSLOT; k++) begin
      if (ok[k] && rank[k] > best) begin
        best = rank[k];
        slot = 2'(k);
      end
    end
    code = lvl_bad ? 4'b0000 : codes[slot];
  end
endmodule

// File: rtl/fcap_state_sel.sv
module fcap_state_sel
  import fcap_pkg::*;
#(
  parameter int VW   = 10,
  parameter int REF1 = 512,
  parameter int REF2 = 256,
  parameter int BAND = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [2:0]    level,
  input  logic          cur_neg,
  input  logic [VW-1:0] vc1,
  input  logic [VW-1:0] vc2,
  input  logic          bal_en1,
  input  logic          bal_en2,
  output logic [3:0]    sw,
  output logic          need1,
  output logic          need2,
  output logic          lvl_err
);
  localparam int NCAP = 2;

  logic [NCAP-1:0] need_w;
  logic [VW-1:0]   vsel [NCAP];
  assign vsel[0] = vc1;
  assign vsel[1] = vc2;

  for (genvar g = 0; g < NCAP; g++) begin : g_cap
    localparam int RF = (g == 0) ? REF1 : REF2;
    fcap_hyst #(.VW(VW), .REF(RF), .BAND(BAND)) u_hyst (
      .clk(clk), .rst_n(rst_n), .v(vsel[g]), .need(need_w[g])
    );
  end

  sw_t        pick_code;
  logic       pick_bad;
  logic [1:0] pick_slot;

  fcap_pick u_pick (
    .level(level), .cur_neg(cur_neg), .need(need_w),
    .en({bal_en2, bal_en1}), .code(pick_code), .lvl_bad(pick_bad),
    .slot(pick_slot)
  );

  sw_t  sw_q;
  logic err_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= 4'b0000;
      err_q <= 1'b0;
    end else if (strobe) begin
      sw_q  <= pick_code;
      err_q <= pick_bad;
    end
  end

  assign sw      = sw_q;
  assign lvl_err = err_q;
  assign need1   = need_w[0];
  assign need2   = need_w[1];
endmodule

// File: rtl/fcap_state_sel_chk.sv
module fcap_state_sel_chk #(
  parameter int VW   = 10,
  parameter int REF1 = 512,
  parameter int REF2 = 256,
  parameter int BAND = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe,
  input logic [2:0]    level,
  input logic [VW-1:0] vc1,
  input logic [VW-1:0] vc2,
  input logic          bal_en1,
  input logic [3:0]    sw,
  input logic          need1,
  input logic          need2,
  input logic          lvl_err
);
  localparam logic [VW:0] LO1 = (VW+1)'(REF1 - BAND);
  localparam logic [VW:0] HI1 = (VW+1)'(REF1 + BAND);
  localparam logic [VW:0] LO2 = (VW+1)'(REF2 - BAND);
  localparam logic [VW:0] HI2 = (VW+1)'(REF2 + BAND);

  a_r2_set1: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, vc1} < LO1) |=> need1);
  a_r2_clr1: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, vc1} > HI1) |=> !need1);
  a_r2_set2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, vc2} < LO2) |=> need2);
  a_r2_clr2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, vc2} > HI2) |=> !need2);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(sw) && $stable(lvl_err)));
  a_r4_low: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && level == 3'd0) |=> sw == 4'b0000);
  a_r4_high: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && level == 3'd4) |=> sw == 4'b1111);
  a_r5_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && level == 3'd2) |=> (sw == 4'b1000 || sw == 4'b0100));
  a_r8_mid_off: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && level == 3'd2 && !bal_en1) |=> sw == 4'b1000);
  a_r10_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && level > 3'd4) |=> (sw == 4'b0000 && lvl_err));
endmodule

bind fcap_state_sel fcap_state_sel_chk #(
  .VW(VW), .REF1(REF1), .REF2(REF2), .BAND(BAND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .level(level), .vc1(vc1),
  .vc2(vc2), .bal_en1(bal_en1), .sw(sw), .need1(need1), .need2(need2),
  .lvl_err(lvl_err)
);

// File: tb/fcap_state_sel_bench.sv
module fcap_state_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 8, REF1 = 128, REF2 = 64, BAND = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strobe = 1'b0;
  logic [2:0]    level = 3'd0;
  logic          cur_neg = 1'b0;
  logic [VW-1:0] vc1 = 8'(REF1);
  logic [VW-1:0] vc2 = 8'(REF2);
  logic          bal_en1 = 1'b1, bal_en2 = 1'b1;
  logic [3:0]    sw;
  logic          need1, need2, lvl_err;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcap_state_sel #(.VW(VW), .REF1(REF1), .REF2(REF2), .BAND(BAND)) u_fcap_state_sel (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .level(level), .cur_neg(cur_neg),
    .vc1(vc1), .vc2(vc2), .bal_en1(bal_en1), .bal_en2(bal_en2), .sw(sw),
    .need1(need1), .need2(need2), .lvl_err(lvl_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Independent model: effect of a code on a capacitor at positive current.
  function automatic int eff(input logic [3:0] c, input int cap);
    int e1, e2;
    e1 = 0; e2 = 0;
    if (c == 4'b0001) begin e1 = 0;  e2 = -1; end
    if (c == 4'b0110) begin e1 = -1; e2 = 1;  end
    if (c == 4'b1010) begin e1 = 1;  e2 = 1;  end
    if (c == 4'b1000) begin e1 = 1;  e2 = 0;  end
    if (c == 4'b0100) begin e1 = -1; e2 = 0;  end
    if (c == 4'b0101) begin e1 = -1; e2 = -1; end
    if (c == 4'b1001) begin e1 = 1;  e2 = -1; end
    if (c == 4'b1110) begin e1 = 0;  e2 = 1;  end
    return (cap == 1) ? e1 : e2;
  endfunction

  function automatic logic [3:0] expect_code(input int lv, input bit neg,
      input bit n1, input bit n2, input bit e1, input bit e2);
    logic [3:0] list [3];
    int n, b1, b2;
    logic [3:0] best;
    if (lv == 0 || lv > 4) return 4'b0000;
    if (lv == 4) return 4'b1111;
    if (lv == 1) begin list[0] = 4'b0001; list[1] = 4'b0110; list[2] = 4'b1010; n = 3; end
    else if (lv == 2) begin list[0] = 4'b1000; list[1] = 4'b0100; list[2] = 4'b0000; n = 2; end
    else begin list[0] = 4'b0101; list[1] = 4'b1001; list[2] = 4'b1110; n = 3; end
    best = 4'b0000; b1 = -9; b2 = -9;
    for (int i = 0; i < n; i++) begin
      int s1, s2, w1, w2;
      w1 = n1 ? 1 : -1;
      w2 = n2 ? 1 : -1;
      s1 = e1 ? eff(list[i], 1) * (neg ? -1 : 1) * w1 : 0;
      s2 = e2 ? eff(list[i], 2) * (neg ? -1 : 1) * w2 : 0;
      if (s2 > b2 || (s2 == b2 && s1 > b1)) begin
        best = list[i]; b1 = s1; b2 = s2;
      end
    end
    return best;
  endfunction

  task automatic set_need(input bit n1, input bit n2);
    vc1 = n1 ? 8'(REF1 - 20) : 8'(REF1 + 20);
    vc2 = n2 ? 8'(REF2 - 20) : 8'(REF2 + 20);
    @(negedge clk);
  endtask

  task automatic strobe_level(input int lv);
    level = 3'(lv);
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 sw", sw, 0);
    check("R1 need1", need1, 0);
    check("R1 need2", need2, 0);
    check("R1 lvl_err", lvl_err, 0);
  endtask

  task automatic t_hyst();
    vc1 = 8'(REF1 - BAND); vc2 = 8'(REF2 - BAND); @(negedge clk);
    check("R2 at low threshold holds 1", need1, 0);
    check("R2 at low threshold holds 2", need2, 0);
    vc1 = 8'(REF1 - BAND - 1); @(negedge clk);
    check("R2 below sets 1", need1, 1);
    check("R2 other untouched", need2, 0);
    vc2 = 8'(REF2 - BAND - 1); @(negedge clk);
    check("R2 below sets 2", need2, 1);
    vc1 = 8'(REF1 + BAND); vc2 = 8'(REF2); @(negedge clk);
    check("R2 at high threshold holds 1", need1, 1);
    check("R2 in band holds 2", need2, 1);
    vc1 = 8'(REF1 + BAND + 1); @(negedge clk);
    check("R2 above clears 1", need1, 0);
    vc2 = 8'(REF2 + BAND + 1); @(negedge clk);
    check("R2 above clears 2", need2, 0);
  endtask

  task automatic t_sweep();
    for (int lv = 0; lv < 8; lv++)
      for (int ng = 0; ng < 2; ng++)
        for (int nn = 0; nn < 4; nn++)
          for (int ee = 0; ee < 4; ee++) begin
            logic [3:0] exp;
            string tag;
            cur_neg = ng[0]; bal_en1 = ee[0]; bal_en2 = ee[1];
            set_need(nn[0], nn[1]);
            strobe_level(lv);
            exp = expect_code(lv, ng[0], nn[0], nn[1], ee[0], ee[1]);
            if (lv == 0 || lv == 4) tag = "R4";
            else if (lv > 4) tag = "R10";
            else if (ee != 3) tag = "R8";
            else if (ng != 0) tag = "R7";
            else tag = "R6";
            check({tag, " sw"}, sw, exp);
            check("R10 lvl_err", lvl_err, (lv > 4) ? 1 : 0);
            if (lv >= 1 && lv <= 3)
              check("R5 member", (sw == expect_code(lv, 0, 0, 0, 0, 0) ||
                    sw == expect_code(lv, 0, 1, 1, 1, 1) ||
                    sw == expect_code(lv, 0, 0, 0, 1, 1) ||
                    sw == expect_code(lv, 0, 1, 0, 1, 1) ||
                    sw == expect_code(lv, 0, 0, 1, 1, 1)) ? 1 : 0, 1);
          end
  endtask

  task automatic t_priority();
    cur_neg = 1'b0; bal_en1 = 1'b1; bal_en2 = 1'b1;
    set_need(1'b1, 1'b0);
    strobe_level(1);
    check("R9 small capacitor rules", sw, 4'b0001);
    bal_en1 = 1'b0; bal_en2 = 1'b0;
    strobe_level(3);
    check("R9 tie to first listed", sw, 4'b0101);
    bal_en1 = 1'b1; bal_en2 = 1'b1;
    set_need(1'b1, 1'b1);
    strobe_level(3);
    check("R9 level3 both want charge", sw, 4'b1110);
  endtask

  task automatic t_gate();
    bal_en1 = 1'b1; bal_en2 = 1'b1; cur_neg = 1'b0;
    strobe_level(4);
    check("R3 strobed", sw, 4'b1111);
    level = 3'd0; @(negedge clk);
    check("R3 no strobe sw held", sw, 4'b1111);
    level = 3'd6; @(negedge clk); @(negedge clk);
    check("R3 no strobe err held", lvl_err, 0);
    check("R3 no strobe sw still held", sw, 4'b1111);
    strobe_level(7);
    check("R10 error raised", lvl_err, 1);
    strobe_level(2);
    check("R10 error cleared", lvl_err, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hyst();
    t_sweep();
    t_priority();
    t_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule